// File: doc/BRIEF.md
# Transfer-Busy Command Gate and Register Lock

This block sits in the control path of a LIN/UART controller, between the processor's register write port and the serial engine. It tracks whether a transfer is in progress. While one is, it suppresses processor writes to the registers that the transfer depends on, and it sorts each command written to the control register into one of three outcomes: deferred, immediate or rejected.

The engine reports three strobes to the block: the start of a transfer (with its direction), the end of each byte, and the completion of the transfer. In LIN mode every transfer makes the block busy. In UART mode only a transmission does, and fewer registers are locked while it runs. A command that cannot be honoured during a transfer is dropped and raises a sticky overrun flag. The transfer keeps running.

All outputs are registered. Write enables and command pulses appear one cycle after the write that causes them.

Top module: `lin_busy_lock`

## Requirements
- R1: After the synchronous reset, `busy`, `ovr_err`, every bit of `reg_we` and all four command pulses are 0.
- R2: In LIN mode (`mode_uart`=0), a `xfer_start` strobe sets `busy` one cycle later, whatever `xfer_tx` is. A `xfer_done` strobe clears `busy` one cycle later.
- R3: In UART mode (`mode_uart`=1), `xfer_start` sets `busy` only when `xfer_tx`=1. A start with `xfer_tx`=0 (a reception) leaves `busy` at 0.
- R4: Register addresses are 0 control, 1 divisor low, 2 divisor high, 3 length, 4 identifier, 5 data and 6 status. A write to address k pulses `reg_we[k]` for one cycle, one cycle after the write. When the block is not busy, no address is locked.
- R5: In LIN mode while busy, writes to addresses 0 to 5 produce no `reg_we` pulse and are dropped silently, with no overrun. For address 0, the command fields are still acted on.
- R6: In UART mode while busy, only addresses 0 and 5 are locked. Addresses 1 to 4 and 6 are written normally.
- R7: The control byte holds the command code in bits [2:0], the enable in bit 3 and the software reset in bit 7. The byte is classed in this order: reset if bit 7 = 1; otherwise kill if bit 3 = 0 or bit 2 = 0; otherwise abort if bits [1:0] = 00; otherwise other. When the block is idle, the matching pulse (`cmd_reset`, `cmd_kill`, `cmd_abort`, `cmd_other`) appears one cycle after the write.
- R8: An abort written while busy gives no pulse at once. `cmd_abort` pulses, and `busy` clears, one cycle after the next `byte_end` strobe.
- R9: A kill written while busy pulses `cmd_kill` and clears `busy` one cycle later, and it discards any pending abort.
- R10: A software reset written while busy pulses `cmd_reset` and clears `busy` one cycle later, and it discards any pending abort.
- R11: Any other command written while busy gives no command pulse, leaves `busy` at 1, and sets `ovr_err` one cycle later.
- R12: `ovr_err` stays set until a write to address 6 with data bit 0 = 1. A write to address 6 with bit 0 = 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_uart | input | 1 | 1 selects UART mode, 0 selects LIN mode |
| xfer_start | input | 1 | Engine strobe: a transfer begins |
| xfer_tx | input | 1 | Direction of the starting transfer, 1 = transmit |
| byte_end | input | 1 | Engine strobe: the current byte boundary is reached |
| xfer_done | input | 1 | Engine strobe: the transfer is complete |
| wr_en | input | 1 | Processor register write request |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | DATA_W | Write data; for address 0 it carries the command fields |
| reg_we | output | NUM_REGS | Per-register write enable, one-hot, registered |
| cmd_abort | output | 1 | Validated abort command pulse |
| cmd_kill | output | 1 | Validated kill command pulse |
| cmd_reset | output | 1 | Validated software-reset command pulse |
| cmd_other | output | 1 | Validated pulse for any other command |
| ovr_err | output | 1 | Sticky overrun flag for a rejected command |
| busy | output | 1 | Transfer in progress |

## Verification
Every result has one register between the stimulus and the output. A write or strobe that is seen at one rising edge shows up on `reg_we`, the command pulses, `busy` and `ovr_err` right after that edge. The bench drives inputs on the falling edge, holds them for one cycle and samples on the next falling edge. It also samples one cycle later, to confirm that the pulses last a single cycle. A deferred abort is checked over several idle cycles before `byte_end` to show that it does not fire early, and then in the cycle after the strobe.

// File: rtl/lin_lock_pkg.sv
package lin_lock_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 7;

  localparam int A_CTRL  = 0;
  localparam int A_DIVL  = 1;
  localparam int A_DIVH  = 2;
  localparam int A_LEN   = 3;
  localparam int A_IDENT = 4;
  localparam int A_DATA  = 5;
  localparam int A_STAT  = 6;

  localparam int CMD_B0   = 0;
  localparam int CMD_B1   = 1;
  localparam int CMD_B2   = 2;
  localparam int ENA_BIT  = 3;
  localparam int SRST_BIT = 7;
  localparam int OVR_BIT  = 0;

  typedef enum logic [1:0] {
    CLS_ABORT = 2'd0,
    CLS_KILL  = 2'd1,
    CLS_RESET = 2'd2,
    CLS_OTHER = 2'd3
  } cmd_cls_e;

  function automatic logic is_locked(input int idx, input logic uart);
    if (uart) return (idx == A_CTRL) || (idx == A_DATA);
    return (idx <= A_DATA);
  endfunction
endpackage

// File: rtl/lock_cmd_class.sv
module lock_cmd_class
  import lin_lock_pkg::*;
#(
  parameter int DATA_W = lin_lock_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] ctrl_byte,
  output cmd_cls_e          cls
);
  always_comb begin
    if (ctrl_byte[SRST_BIT])
      cls = CLS_RESET;
    else if (!ctrl_byte[ENA_BIT] || !ctrl_byte[CMD_B2])
      cls = CLS_KILL;
    else if (!ctrl_byte[CMD_B1] && !ctrl_byte[CMD_B0])
      cls = CLS_ABORT;
    else
      cls = CLS_OTHER;
  end
endmodule

// File: rtl/lock_busy_ctl.sv
module lock_busy_ctl
  import lin_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     mode_uart,
  input  logic     xfer_start,
  input  logic     xfer_tx,
  input  logic     byte_end,
  input  logic     xfer_done,
  input  logic     ctrl_wr,
  input  cmd_cls_e cls,
  output logic     busy,
  output logic     abort_rel
);
  logic pend;
  logic imm_stop;
  logic start_ok;

  assign imm_stop  = ctrl_wr && (cls == CLS_KILL || cls == CLS_RESET);
  assign start_ok  = xfer_start && (!mode_uart || xfer_tx);
  assign abort_rel = pend && byte_end && !imm_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (imm_stop || abort_rel || xfer_done)
        busy <= 1'b0;
      else if (start_ok)
        busy <= 1'b1;

      if (imm_stop || abort_rel || xfer_done)
        pend <= 1'b0;
      else if (busy && ctrl_wr && cls == CLS_ABORT)
        pend <= 1'b1;
    end
  end
endmodule

// File: rtl/lock_wr_gate.sv
module lock_wr_gate
  import lin_lock_pkg::*;
#(
  parameter int ADDR_W   = lin_lock_pkg::ADDR_W,
  parameter int NUM_REGS = lin_lock_pkg::NUM_REGS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_uart,
  input  logic                busy,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_REGS-1:0] reg_we
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    logic blocked;
    assign hit     = wr_en && (wr_addr == ADDR_W'(g));
    assign blocked = busy && is_locked(g, mode_uart);
    always_ff @(posedge clk) begin
      if (rst) reg_we[g] <= 1'b0;
      else     reg_we[g] <= hit && !blocked;
    end
  end
endmodule

// File: rtl/lin_busy_lock.sv
module lin_busy_lock
  import lin_lock_pkg::*;
#(
  parameter int ADDR_W   = lin_lock_pkg::ADDR_W,
  parameter int DATA_W   = lin_lock_pkg::DATA_W,
  parameter int NUM_REGS = lin_lock_pkg::NUM_REGS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_uart,
  input  logic                xfer_start,
  input  logic                xfer_tx,
  input  logic                byte_end,
  input  logic                xfer_done,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_REGS-1:0] reg_we,
  output logic                cmd_abort,
  output logic                cmd_kill,
  output logic                cmd_reset,
  output logic                cmd_other,
  output logic                ovr_err,
  output logic                busy
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(A_STAT);

  cmd_cls_e cls;
  logic     ctrl_wr;
  logic     abort_rel;
  logic     ovr_clr;

  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  assign ovr_clr = wr_en && (wr_addr == STAT_ADDR) && wr_data[OVR_BIT];

  lock_cmd_class #(.DATA_W(DATA_W)) u_class (
    .ctrl_byte (wr_data),
    .cls       (cls)
  );

  lock_busy_ctl u_busy (
    .clk        (clk),
    .rst        (rst),
    .mode_uart  (mode_uart),
    .xfer_start (xfer_start),
    .xfer_tx    (xfer_tx),
    .byte_end   (byte_end),
    .xfer_done  (xfer_done),
    .ctrl_wr    (ctrl_wr),
    .cls        (cls),
    .busy       (busy),
    .abort_rel  (abort_rel)
  );

  lock_wr_gate #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .mode_uart (mode_uart),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .reg_we    (reg_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_abort <= 1'b0;
      cmd_kill  <= 1'b0;
      cmd_reset <= 1'b0;
      cmd_other <= 1'b0;
      ovr_err   <= 1'b0;
    end else begin
      cmd_abort <= abort_rel || (ctrl_wr && !busy && cls == CLS_ABORT);
      cmd_kill  <= ctrl_wr && cls == CLS_KILL;
      cmd_reset <= ctrl_wr && cls == CLS_RESET;
      cmd_other <= ctrl_wr && !busy && cls == CLS_OTHER;
      if (ctrl_wr && busy && cls == CLS_OTHER)
        ovr_err <= 1'b1;
      else if (ovr_clr)
        ovr_err <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_busy_lock_chk.sv
module lin_busy_lock_chk
  import lin_lock_pkg::*;
#(
  parameter int ADDR_W   = lin_lock_pkg::ADDR_W,
  parameter int DATA_W   = lin_lock_pkg::DATA_W,
  parameter int NUM_REGS = lin_lock_pkg::NUM_REGS
) (
  input logic                clk,
  input logic                rst,
  input logic                mode_uart,
  input logic                xfer_start,
  input logic                xfer_tx,
  input logic                byte_end,
  input logic                xfer_done,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [NUM_REGS-1:0] reg_we,
  input logic                cmd_abort,
  input logic                cmd_kill,
  input logic                cmd_reset,
  input logic                cmd_other,
  input logic                ovr_err,
  input logic                busy
);
  logic ctrl_w;
  logic is_kill;
  logic is_other;
  assign ctrl_w   = wr_en && wr_addr == ADDR_W'(A_CTRL);
  assign is_kill  = !wr_data[SRST_BIT] && (!wr_data[ENA_BIT] || !wr_data[CMD_B2]);
  assign is_other = !wr_data[SRST_BIT] && wr_data[ENA_BIT] && wr_data[CMD_B2]
                    && (wr_data[CMD_B1] || wr_data[CMD_B0]);

  // R4
  reg_we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_we));

  // R7
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_abort, cmd_kill, cmd_reset, cmd_other}));

  // R5
  lin_len_lock_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !mode_uart && wr_en && wr_addr == ADDR_W'(A_LEN) |=> !reg_we[A_LEN]);

  // R6
  uart_div_open_chk: assert property (@(posedge clk) disable iff (rst)
    busy && mode_uart && wr_en && wr_addr == ADDR_W'(A_DIVL) |=> reg_we[A_DIVL]);

  // R3
  uart_rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && mode_uart && xfer_start && !xfer_tx |=> !busy);

  // R9
  kill_stop_chk: assert property (@(posedge clk) disable iff (rst)
    busy && ctrl_w && is_kill |=> !busy && cmd_kill);

  // R11
  other_reject_chk: assert property (@(posedge clk) disable iff (rst)
    busy && ctrl_w && is_other && !xfer_done && !byte_end |=> busy && ovr_err && !cmd_other);

  // R12
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_err && !(wr_en && wr_addr == ADDR_W'(A_STAT) && wr_data[OVR_BIT]) |=> ovr_err);
endmodule

bind lin_busy_lock lin_busy_lock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst(rst), .mode_uart(mode_uart), .xfer_start(xfer_start),
  .xfer_tx(xfer_tx), .byte_end(byte_end), .xfer_done(xfer_done),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .reg_we(reg_we),
  .cmd_abort(cmd_abort), .cmd_kill(cmd_kill), .cmd_reset(cmd_reset),
  .cmd_other(cmd_other), .ovr_err(ovr_err), .busy(busy)
);

// File: tb/lin_busy_lock_test.sv
module lin_busy_lock_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_uart = 1'b0;
  logic       xfer_start = 1'b0;
  logic       xfer_tx = 1'b0;
  logic       byte_end = 1'b0;
  logic       xfer_done = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] reg_we;
  logic       cmd_abort, cmd_kill, cmd_reset, cmd_other, ovr_err, busy;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lin_busy_lock uut (
    .clk(clk), .rst(rst), .mode_uart(mode_uart), .xfer_start(xfer_start),
    .xfer_tx(xfer_tx), .byte_end(byte_end), .xfer_done(xfer_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .reg_we(reg_we),
    .cmd_abort(cmd_abort), .cmd_kill(cmd_kill), .cmd_reset(cmd_reset),
    .cmd_other(cmd_other), .ovr_err(ovr_err), .busy(busy)
  );

  // {mode, busy_pre, addr, data, reg_we, {abort,kill,reset,other}, busy_post, ovr}
  localparam int NV = 16;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0,1'b0,3'd3,8'h00,7'b0001000,4'b0000,1'b0,1'b0}, // R4 idle write
    {1'b0,1'b1,3'd3,8'h00,7'b0000000,4'b0000,1'b1,1'b0}, // R5 length locked
    {1'b0,1'b1,3'd1,8'h00,7'b0000000,4'b0000,1'b1,1'b0}, // R5 divisor locked
    {1'b0,1'b1,3'd5,8'h00,7'b0000000,4'b0000,1'b1,1'b0}, // R5 data locked
    {1'b1,1'b1,3'd1,8'h00,7'b0000010,4'b0000,1'b1,1'b0}, // R6 divisor open
    {1'b1,1'b1,3'd4,8'h00,7'b0010000,4'b0000,1'b1,1'b0}, // R6 identifier open
    {1'b1,1'b1,3'd5,8'h00,7'b0000000,4'b0000,1'b1,1'b0}, // R6 data locked
    {1'b0,1'b0,3'd0,8'h0C,7'b0000001,4'b1000,1'b0,1'b0}, // R7 idle abort
    {1'b0,1'b0,3'd0,8'h0D,7'b0000001,4'b0001,1'b0,1'b0}, // R7 idle other
    {1'b0,1'b1,3'd0,8'h0D,7'b0000000,4'b0000,1'b1,1'b1}, // R11 rejected
    {1'b0,1'b1,3'd0,8'h05,7'b0000000,4'b0100,1'b0,1'b0}, // R9 kill by enable
    {1'b0,1'b1,3'd0,8'h0B,7'b0000000,4'b0100,1'b0,1'b0}, // R9 kill by code bit 2
    {1'b0,1'b1,3'd0,8'h8D,7'b0000000,4'b0010,1'b0,1'b0}, // R10 soft reset
    {1'b0,1'b1,3'd0,8'h0C,7'b0000000,4'b0000,1'b1,1'b0}, // R8 abort deferred
    {1'b1,1'b1,3'd0,8'h0D,7'b0000000,4'b0000,1'b1,1'b1}, // R11 rejected in UART
    {1'b0,1'b1,3'd6,8'h01,7'b1000000,4'b0000,1'b1,1'b0}  // R5 status never locked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobe_start(input logic tx);
    xfer_start = 1'b1;
    xfer_tx = tx;
    @(negedge clk);
    xfer_start = 1'b0;
    xfer_tx = 1'b0;
  endtask

  task automatic write(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [3:0] cmds();
    return {cmd_abort, cmd_kill, cmd_reset, cmd_other};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 ovr", ovr_err, 0);
    chk("R1 we", reg_we, 0);
    chk("R1 cmd", cmds(), 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      do_reset();
      mode_uart = v[25];
      if (v[24]) strobe_start(1'b1);
      write(v[23:21], v[20:13]);
      chk($sformatf("vec%0d we", i), reg_we, v[12:6]);
      chk($sformatf("vec%0d cmd", i), cmds(), v[5:2]);
      chk($sformatf("vec%0d busy", i), busy, v[1]);
      chk($sformatf("vec%0d ovr", i), ovr_err, v[0]);
      @(negedge clk);
      chk($sformatf("vec%0d pulse width", i), {reg_we, cmds()}, 0);
    end

    // R2 LIN start regardless of direction, done clears
    do_reset();
    mode_uart = 1'b0;
    strobe_start(1'b0);
    chk("R2 busy set", busy, 1);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk("R2 busy clear", busy, 0);

    // R3 UART reception does not set busy, transmission does
    do_reset();
    mode_uart = 1'b1;
    strobe_start(1'b0);
    chk("R3 rx not busy", busy, 0);
    strobe_start(1'b1);
    chk("R3 tx busy", busy, 1);

    // R8 deferred abort fires after byte_end
    do_reset();
    mode_uart = 1'b0;
    strobe_start(1'b1);
    write(3'd0, 8'h0C);
    repeat (3) begin
      chk("R8 no early abort", cmd_abort, 0);
      chk("R8 still busy", busy, 1);
      @(negedge clk);
    end
    byte_end = 1'b1;
    @(negedge clk);
    byte_end = 1'b0;
    chk("R8 abort pulse", cmd_abort, 1);
    chk("R8 busy cleared", busy, 0);
    @(negedge clk);
    chk("R8 single pulse", cmd_abort, 0);

    // R9 kill drops a pending abort
    do_reset();
    strobe_start(1'b1);
    write(3'd0, 8'h0C);
    write(3'd0, 8'h05);
    chk("R9 kill pulse", cmd_kill, 1);
    strobe_start(1'b1);
    byte_end = 1'b1;
    @(negedge clk);
    byte_end = 1'b0;
    chk("R9 pending dropped", cmd_abort, 0);
    chk("R9 new transfer busy", busy, 1);

    // R12 sticky overrun and write-one-to-clear
    do_reset();
    strobe_start(1'b1);
    write(3'd0, 8'h0E);
    chk("R11 ovr set", ovr_err, 1);
    chk("R11 still busy", busy, 1);
    repeat (4) @(negedge clk);
    chk("R12 ovr held", ovr_err, 1);
    write(3'd6, 8'hFE);
    chk("R12 bit0 zero keeps", ovr_err, 1);
    write(3'd6, 8'h01);
    chk("R12 cleared", ovr_err, 0);
    // R5 blocked plain write raises no overrun
    write(3'd3, 8'h55);
    chk("R5 no ovr on plain write", ovr_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule